// File: doc/BRIEF.md
# Stepped Single-Word Bus Master

This block is a bus master on a synchronous, single-clock parallel bus. Each step-enable pulse makes it perform one single-word transaction. The address comes from an internal counter. A build parameter fixes the flavour. The read flavour requests a word and stores the returned value in a holding register. The write flavour sends a fixed word. In both flavours the counter moves to the next word once the transaction finishes, so a series of pulses walks through consecutive addresses.

Every transaction follows the same four-phase sequence: idle, issue, await-acknowledge and finish. In the issue cycle the address strobe is asserted (low) for exactly one clock, with the address and any write data valid. The machine then waits for as long as the slave takes to pull the acknowledge low. In the read flavour, the slave places the word on the data input in the cycle after the acknowledge, and the machine captures it at the end of that cycle. A status output tells the host when the master is idle and the bus is free for other use. A synchronous reset returns the machine to idle from any phase and clears the counter.

Top module: `stepped_bus_master`

## Requirements
- R1: While reset is held and directly after it: inInit=1, asN=1, wrN=1, addrOut=0 and readData=0.
- R2: While idle with stepEn low, the machine stays idle: inInit stays 1, asN stays 1 and addrOut does not change.
- R3: When stepEn is high at a clock edge while idle, asN is 0 and inInit is 0 in the following cycle, and asN is 1 again in the cycle after that.
- R4: In the read flavour wrN stays 1. In the write flavour wrN is 0 from the strobe cycle through the whole acknowledge wait, and 1 in every other cycle.
- R5: After the strobe cycle the machine waits with asN=1 and inInit=0 for any number of cycles until ackN is 0 at a clock edge.
- R6: Read flavour: the value on dataIn during the cycle after the acknowledge appears on readData after the next edge. Values present at other times are not captured.
- R7: Write flavour: during the strobe cycle dataOut equals the WRITE_WORD parameter.
- R8: In the cycle after the acknowledge the machine is still busy (inInit=0). At the next edge it returns to idle (inInit=1) with no further condition.
- R9: addrOut is the counter zero-extended to the bus width and stays constant through a transaction. The counter rises by one as the machine returns to idle, and wraps from 2^CNT_W-1 to 0.
- R10: Reset asserted in any phase returns the machine to idle (inInit=1, asN=1, wrN=1) with addrOut=0.
- R11: A stepEn pulse while a transaction is in progress is ignored: no second strobe follows the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | One-cycle pulse that starts one transaction |
| ackN | input | 1 | Slave acknowledge, active low |
| dataIn | input | DATA_W | Read data from the bus |
| asN | output | 1 | Address strobe, active low, one cycle per transaction |
| wrN | output | 1 | Direction: 1 for read, 0 for write |
| addrOut | output | ADDR_W | Transaction address (zero-extended counter) |
| dataOut | output | DATA_W | Write data (the fixed word in the write flavour, zero otherwise) |
| inInit | output | 1 | 1 while the master is idle and the bus is free |
| readData | output | DATA_W | Last word captured by a read |

## Verification
The checks built into the RTL assume that reset is synchronous and that the slave pulls ackN low only during the acknowledge wait, never in the strobe cycle itself. They also assume that stepEn comes as a single-cycle pulse. The bench keeps to these assumptions. It raises step-enable for one cycle, asserts the acknowledge only once the strobe has gone high again, and holds it for one cycle. It presents the read word only in the cycle after the acknowledge and drives a different value everywhere else. It deliberately pulses step-enable during the acknowledge wait to show that the pulse is ignored, and it applies reset both during the acknowledge wait and during the strobe cycle.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  // Four phases shared by both flavours; the order is the transaction sequence.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_AWAIT  = 2'd2,
    ST_FINISH = 2'd3
  } sbmState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic strobe;    // address strobe cycle
    logic writeLow;  // drive the direction line low
    logic capture;   // latch the read word
    logic advance;   // step the address counter
    logic idle;      // master idle, bus free
  } sbmCtl_t;

endpackage

// File: rtl/sbm_control.sv
module sbm_control
  import sbm_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    stepEn,
  input  logic    ackN,
  output sbmCtl_t ctl
);

  sbmState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (stepEn) stateNext = ST_ISSUE;
      ST_ISSUE:  stateNext = ST_AWAIT;
      ST_AWAIT:  if (!ackN) stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctl.strobe   = (state == ST_ISSUE);
    ctl.writeLow = IS_WRITE && ((state == ST_ISSUE) || (state == ST_AWAIT));
    ctl.capture  = !IS_WRITE && (state == ST_FINISH);
    ctl.advance  = (state == ST_FINISH);
    ctl.idle     = (state == ST_IDLE);
  end

  // R2: no step, no departure from idle
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !stepEn) |=> (state == ST_IDLE));

  // R3: the issue phase lasts one cycle
  a_r3_issue_once: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ISSUE) |=> (state == ST_AWAIT));

  // R5: keep waiting while acknowledge is high
  a_r5_hold_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AWAIT && ackN) |=> (state == ST_AWAIT));

  // R8: finish always returns to idle
  a_r8_back_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINISH) |=> (state == ST_IDLE));

  // R10: reset lands in idle
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE));

endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 16,
  parameter bit                IS_WRITE   = 1'b0,
  parameter logic [DATA_W-1:0] WRITE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  sbmCtl_t           ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic              asN,
  output logic              wrN,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              inInit,
  output logic [DATA_W-1:0] readData
);

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_ONE = cnt_t'(1);

  cnt_t              count;
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (ctl.advance) count <= count + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)              holdReg <= '0;
    else if (ctl.capture) holdReg <= dataIn;
  end

  generate
    if (IS_WRITE) begin : g_wrData
      assign dataOut = WRITE_WORD;
    end else begin : g_rdData
      assign dataOut = '0;
    end
  endgenerate

  assign asN      = ~ctl.strobe;
  assign wrN      = ~ctl.writeLow;
  assign inInit   = ctl.idle;
  assign addrOut  = ADDR_W'(count);
  assign readData = holdReg;

  // R3: strobe never lasts two cycles
  a_r3_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    !asN |=> asN);

  // R9: address constant unless advancing
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    !ctl.advance |=> $stable(addrOut));

  // R9: advance is exactly one step (modulo counter width)
  a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> (count == cnt_t'($past(count) + CNT_ONE)));

  // R6: read word only changes on capture
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !ctl.capture |=> $stable(readData));

  // R8: busy flag high during strobe
  a_r8_busy_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !asN |-> !inInit);

  generate
    if (IS_WRITE) begin : g_wrChk
      // R4: write direction accompanies the strobe
      a_r4_write_dir: assert property (@(posedge clk) disable iff (rst)
        !asN |-> !wrN);
    end
  endgenerate

  // R10: counter cleared by reset
  a_r10_reset_count: assert property (@(posedge clk)
    rst |=> (count == '0));

endmodule

// File: rtl/stepped_bus_master.sv
module stepped_bus_master
  import sbm_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 16,
  parameter bit                IS_WRITE   = 1'b0,
  parameter logic [DATA_W-1:0] WRITE_WORD = 32'hC0DE_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stepEn,
  input  logic              ackN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              asN,
  output logic              wrN,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              inInit,
  output logic [DATA_W-1:0] readData
);

  sbmCtl_t ctl;

  sbm_control #(
    .IS_WRITE(IS_WRITE)
  ) u_control (
    .clk   (clk),
    .rst   (rst),
    .stepEn(stepEn),
    .ackN  (ackN),
    .ctl   (ctl)
  );

  sbm_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .IS_WRITE  (IS_WRITE),
    .WRITE_WORD(WRITE_WORD)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .asN     (asN),
    .wrN     (wrN),
    .addrOut (addrOut),
    .dataOut (dataOut),
    .inInit  (inInit),
    .readData(readData)
  );

endmodule

// File: tb/test_stepped_bus_master.sv
`timescale 1ns/1ps
module test_stepped_bus_master;

  localparam logic [31:0] WV = 32'h5A5A_C3C3;
  localparam int WRAP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        rStep = 1'b0, rAck = 1'b1;
  logic [31:0] rDin = '0;
  logic        rAsN, rWrN, rInit;
  logic [31:0] rAddr, rDout, rRd;

  logic        wStep = 1'b0, wAck = 1'b1;
  logic [31:0] wDin = '0;
  logic        wAsN, wWrN, wInit;
  logic [31:0] wAddr, wDout, wRd;

  int nChecks = 0;
  int nFail   = 0;
  int expR    = 0;
  int expW    = 0;

  stepped_bus_master #(.CNT_W(3), .IS_WRITE(1'b0), .WRITE_WORD(WV)) i_stepped_bus_master (
    .clk(clk), .rst(rst), .stepEn(rStep), .ackN(rAck), .dataIn(rDin),
    .asN(rAsN), .wrN(rWrN), .addrOut(rAddr), .dataOut(rDout),
    .inInit(rInit), .readData(rRd));

  stepped_bus_master #(.CNT_W(3), .IS_WRITE(1'b1), .WRITE_WORD(WV)) i_stepped_bus_master_wr (
    .clk(clk), .rst(rst), .stepEn(wStep), .ackN(wAck), .dataIn(wDin),
    .asN(wAsN), .wrN(wWrN), .addrOut(wAddr), .dataOut(wDout),
    .inInit(wInit), .readData(wRd));

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nextEdge();
    @(posedge clk);
    #2;
  endtask

  task automatic testReset();
    checkEq("R1 read inInit",   32'(rInit), 32'd1);
    checkEq("R1 read asN",      32'(rAsN),  32'd1);
    checkEq("R1 read wrN",      32'(rWrN),  32'd1);
    checkEq("R1 read addr",     rAddr,      32'd0);
    checkEq("R1 read data reg", rRd,        32'd0);
    checkEq("R1 write inInit",  32'(wInit), 32'd1);
    checkEq("R1 write wrN",     32'(wWrN),  32'd1);
    checkEq("R1 write addr",    wAddr,      32'd0);
  endtask

  task automatic testIdle(input int n);
    for (int i = 0; i < n; i++) begin
      nextEdge();
      checkEq("R2 read stays idle", 32'(rInit), 32'd1);
      checkEq("R2 no strobe",       32'(rAsN),  32'd1);
      checkEq("R2 addr held",       rAddr,      32'(expR));
      checkEq("R2 write stays idle", 32'(wInit), 32'd1);
    end
  endtask

  task automatic doRead(input logic [31:0] data, input int delay, input bit poke);
    checkEq("R9 read addr before", rAddr, 32'(expR));
    rStep = 1'b1;
    nextEdge();
    rStep = 1'b0;
    checkEq("R3 strobe low",    32'(rAsN),  32'd0);
    checkEq("R3 busy",          32'(rInit), 32'd0);
    checkEq("R4 read wr high",  32'(rWrN),  32'd1);
    checkEq("R9 addr on strobe", rAddr,     32'(expR));
    nextEdge();
    checkEq("R3 strobe single", 32'(rAsN),  32'd1);
    for (int i = 0; i < delay; i++) begin
      if (poke) rStep = 1'b1;
      nextEdge();
      rStep = 1'b0;
      checkEq("R5 waiting no strobe", 32'(rAsN),  32'd1);
      checkEq("R5 waiting busy",      32'(rInit), 32'd0);
      checkEq("R4 read wr high wait", 32'(rWrN),  32'd1);
    end
    rAck = 1'b0;
    rDin = ~data;
    nextEdge();
    rAck = 1'b1;
    rDin = data;
    checkEq("R8 busy in load", 32'(rInit), 32'd0);
    checkEq("R9 addr in load", rAddr, 32'(expR));
    nextEdge();
    rDin = 32'hDEAD_BEEF;
    expR = (expR + 1) % WRAP;
    checkEq("R6 captured word", rRd,        data);
    checkEq("R9 addr advanced", rAddr,      32'(expR));
    checkEq("R8 back idle",     32'(rInit), 32'd1);
    if (poke) begin
      nextEdge();
      checkEq("R11 no second strobe", 32'(rAsN),  32'd1);
      checkEq("R11 still idle",       32'(rInit), 32'd1);
      checkEq("R6 word held",         rRd,        data);
    end
  endtask

  task automatic doWrite(input int delay);
    checkEq("R9 write addr before", wAddr, 32'(expW));
    checkEq("R4 write wr high idle", 32'(wWrN), 32'd1);
    wStep = 1'b1;
    nextEdge();
    wStep = 1'b0;
    checkEq("R3 write strobe low", 32'(wAsN), 32'd0);
    checkEq("R4 write wr low",     32'(wWrN), 32'd0);
    checkEq("R7 write data",       wDout,     WV);
    nextEdge();
    checkEq("R3 write strobe single", 32'(wAsN), 32'd1);
    checkEq("R4 wr low in wait",      32'(wWrN), 32'd0);
    for (int i = 0; i < delay; i++) begin
      nextEdge();
      checkEq("R5 write waiting",    32'(wInit), 32'd0);
      checkEq("R4 wr low still",     32'(wWrN),  32'd0);
    end
    wAck = 1'b0;
    nextEdge();
    wAck = 1'b1;
    checkEq("R4 wr high in terminate", 32'(wWrN),  32'd1);
    checkEq("R8 busy in terminate",    32'(wInit), 32'd0);
    nextEdge();
    expW = (expW + 1) % WRAP;
    checkEq("R9 write addr advanced", wAddr,      32'(expW));
    checkEq("R8 write back idle",     32'(wInit), 32'd1);
  endtask

  task automatic abortRead();
    rStep = 1'b1;
    nextEdge();
    rStep = 1'b0;
    nextEdge();
    rst = 1'b1;
    nextEdge();
    rst = 1'b0;
    expR = 0;
    expW = 0;
    checkEq("R10 read idle after abort", 32'(rInit), 32'd1);
    checkEq("R10 read no strobe",        32'(rAsN),  32'd1);
    checkEq("R10 read addr cleared",     rAddr,      32'd0);
    nextEdge();
    checkEq("R10 read stays idle",       32'(rInit), 32'd1);
  endtask

  task automatic abortWrite();
    wStep = 1'b1;
    nextEdge();
    wStep = 1'b0;
    rst = 1'b1;
    nextEdge();
    rst = 1'b0;
    expR = 0;
    expW = 0;
    checkEq("R10 write idle after abort", 32'(wInit), 32'd1);
    checkEq("R10 write no strobe",        32'(wAsN),  32'd1);
    checkEq("R10 write wr released",     32'(wWrN),  32'd1);
    checkEq("R10 write addr cleared",     wAddr,      32'd0);
  endtask

  task automatic testWrap();
    for (int i = 0; i < WRAP; i++) doRead(32'h1000_0000 + 32'(i), i % 2, 1'b0);
    checkEq("R9 counter wrapped", rAddr, 32'd0);
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    nextEdge();
    nextEdge();
    testReset();
    rst = 1'b0;
    nextEdge();
    testReset();
    testIdle(5);
    doRead(32'hA5A5_0F0F, 0, 1'b0);
    doRead(32'h1234_5678, 3, 1'b0);
    doRead(32'hFFFF_0000, 2, 1'b1);
    doWrite(0);
    doWrite(4);
    testIdle(2);
    abortRead();
    doWrite(1);
    abortWrite();
    testWrap();
    finish();
  end

endmodule